// File: doc/BRIEF.md
# In-Order Commit Unit

This block sits at the retire end of an out-of-order core. It owns the head pointer of a circular reorder buffer and, each cycle, looks at a window of the oldest entries. Each entry provides a done bit, a fault code (zero means no fault), a branch flag, an end-of-flow marker and a destination tag. The unit picks the entries that may retire this cycle. It reports them to the register file and free-list logic as a slot mask with the matching destination tags, then advances the head pointer by the number retired.

Faults seen during execution live only in their entries until they reach the head. At that point the unit raises a trap with the fault cause and a flush. Instructions that are split into several micro-ops (a flow) retire only when the whole flow has completed. An external interrupt request is taken only at a flow boundary and never in preference to a trap.

The allocator owns the tail pointer and drives it in. A mispredict flush is seen here only as the tail moving back. After a trap or an interrupt flush, the allocator sets the tail equal to the head.

Top module: `commit_retire_unit`

## Requirements
- R1: Out of reset `head_ptr` is 0 and no outputs are active. Each cycle the retire mask holds a contiguous run of slots from slot 0, at most CW wide. `head_ptr` advances by the number of set bits on the next edge. `ret_tag` carries a slot's destination tag when that slot retires and zero otherwise.
- R2: Retirement stops at the first entry whose done bit is clear, even if younger entries are done.
- R3: At most one entry with the branch flag retires per cycle. A second branch ends the group and retires in a later cycle.
- R4: A flow is a run of micro-ops ending at the entry whose end-of-flow bit is 1; a single micro-op has that bit set. No micro-op retires until every micro-op from it through its flow end is done, fault-free and present within the SCAN-entry window.
- R5: A flow longer than CW retires CW micro-ops per cycle over several cycles, including across the buffer wrap point.
- R6: A nonzero fault code on an entry that is not at the head raises nothing. The retire group ends just before that entry.
- R7: When the flow at the head holds a faulting micro-op and every micro-op before it in the flow is done, `trap` and `flush` are 1 for that cycle. `trap_cause` is the code of the first faulting micro-op, no slot retires and the head holds. `trap_cause` is zero whenever `trap` is 0.
- R8: Entries at or beyond the tail (occupancy = tail − head) never retire and never trap. A fault left in a slot removed by a mispredict or a flush is therefore never raised.
- R9: Pointers are one bit wider than the index. Equal index bits with different wrap bits mean a full buffer, in which all DEPTH entries are eligible.
- R10: While a flow is partly retired, a pending `irq_req` waits. In the first cycle with the head at a flow boundary, `irq_take` and `flush` are 1, no slot retires and the head holds.
- R11: While `irq_req` is 1, the retire group ends at the first end-of-flow entry it retires.
- R12: If a trap and an interrupt would be taken in the same cycle, the trap wins and `irq_take` stays 0. The interrupt is taken later while the request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tail_ptr | input | PW+1 | Allocation pointer with wrap bit |
| ent_done | input | SCAN | Done bit per window slot (slot 0 = head) |
| ent_fault | input | SCAN*FLT_W | Fault code per window slot, 0 = none |
| ent_branch | input | CW | Branch flag per retire slot |
| ent_eof | input | SCAN | End-of-flow marker per window slot |
| ent_tag | input | CW*TAG_W | Destination tag per retire slot |
| irq_req | input | 1 | Level interrupt request, held until taken |
| head_ptr | output | PW+1 | Oldest-entry pointer with wrap bit |
| ret_mask | output | CW | Slots retiring this cycle |
| ret_tag | output | CW*TAG_W | Destination tags of retiring slots |
| trap | output | 1 | Fault taken at the head |
| trap_cause | output | FLT_W | Fault code of the trap |
| irq_take | output | 1 | Interrupt taken this cycle |
| flush | output | 1 | Machine flush (trap or interrupt) |

## Verification
Two pairs of functions can collide in one cycle.

- **Trap versus interrupt:** the bench places a faulting entry at the head while `irq_req` is already high. It expects the trap with its cause and no `irq_take`, then the interrupt in the cycle after the tail is pulled back to the head.
- **Flow completion versus interrupt:** the bench raises the request while a six-micro-op flow is half retired. It expects the group to stop at the flow end (not at the width limit) and the interrupt one cycle later with nothing retired.

// File: rtl/commit_retire_unit.sv
module commit_retire_unit #(
  parameter int CW    = 4,
  parameter int SCAN  = 8,
  parameter int DEPTH = 16,
  parameter int FLT_W = 4,
  parameter int TAG_W = 6,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PW:0]           tail_ptr,
  input  logic [SCAN-1:0]       ent_done,
  input  logic [SCAN*FLT_W-1:0] ent_fault,
  input  logic [CW-1:0]         ent_branch,
  input  logic [SCAN-1:0]       ent_eof,
  input  logic [CW*TAG_W-1:0]   ent_tag,
  input  logic                  irq_req,
  output logic [PW:0]           head_ptr,
  output logic [CW-1:0]         ret_mask,
  output logic [CW*TAG_W-1:0]   ret_tag,
  output logic                  trap,
  output logic [FLT_W-1:0]      trap_cause,
  output logic                  irq_take,
  output logic                  flush
);
  localparam logic [PW:0] ONE = {{PW{1'b0}}, 1'b1};

  logic [PW:0]      head_q, occ, cnt;
  logic             open_q;
  logic [SCAN-1:0]  vld, flt, ok;
  logic             hit, alive, run, stop, br, last_eof;
  logic [FLT_W-1:0] cause;
  logic [CW-1:0]    sel;

  assign occ = tail_ptr - head_q;

  always_comb begin
    run = 1'b0;
    for (int k = SCAN - 1; k >= 0; k--) begin
      vld[k] = (PW+1)'(k) < occ;
      flt[k] = |ent_fault[k*FLT_W +: FLT_W];
      run    = vld[k] & ent_done[k] & ~flt[k] & (ent_eof[k] | run);
      ok[k]  = run;
    end
  end

  always_comb begin
    hit   = 1'b0;
    cause = '0;
    alive = 1'b1;
    for (int k = 0; k < SCAN; k++) begin
      if (alive) begin
        if (!(vld[k] && ent_done[k])) alive = 1'b0;
        else if (flt[k]) begin
          hit   = 1'b1;
          cause = ent_fault[k*FLT_W +: FLT_W];
          alive = 1'b0;
        end
        else if (ent_eof[k]) alive = 1'b0;
      end
    end
  end

  assign trap       = hit;
  assign trap_cause = cause;
  assign irq_take   = irq_req & ~open_q & ~hit;
  assign flush      = hit | irq_take;

  always_comb begin
    sel      = '0;
    cnt      = '0;
    br       = 1'b0;
    last_eof = 1'b1;
    stop     = flush;
    for (int k = 0; k < CW; k++) begin
      if (!stop) begin
        if (ok[k] && !(br && ent_branch[k])) begin
          sel[k]   = 1'b1;
          cnt      = cnt + ONE;
          br       = br | ent_branch[k];
          last_eof = ent_eof[k];
          if (irq_req && ent_eof[k]) stop = 1'b1;
        end else begin
          stop = 1'b1;
        end
      end
    end
  end

  generate
    for (genvar k = 0; k < CW; k++) begin : g_tag
      assign ret_tag[k*TAG_W +: TAG_W] = sel[k] ? ent_tag[k*TAG_W +: TAG_W] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      open_q <= 1'b0;
    end else begin
      head_q <= head_q + cnt;
      if (|sel) open_q <= ~last_eof;
    end
  end

  assign head_ptr = head_q;
  assign ret_mask = sel;
endmodule

// File: rtl/commit_retire_chk.sv
module commit_retire_chk #(
  parameter int CW    = 4,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW:0]   tail_ptr,
  input logic [PW:0]   head_ptr,
  input logic [CW-1:0] ent_done,
  input logic [CW-1:0] ent_eof,
  input logic [CW-1:0] ent_branch,
  input logic [CW-1:0] ret_mask,
  input logic          trap,
  input logic          irq_take,
  input logic          flush
);
  logic [PW:0] nret, occ;
  logic        openc, lastq;

  assign nret = (PW+1)'($countones(ret_mask));
  assign occ  = tail_ptr - head_ptr;

  always_comb begin
    lastq = 1'b1;
    for (int k = 0; k < CW; k++) if (ret_mask[k]) lastq = ent_eof[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) openc <= 1'b0;
    else if (|ret_mask) openc <= ~lastq;
  end

  assert_head_adv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> head_ptr == $past(head_ptr) + $past(nret));

  assert_done_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_mask & ~ent_done) == '0);

  assert_one_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ret_mask & ent_branch) <= 1);

  assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap || irq_take) |-> (ret_mask == '0 && flush));

  assert_within_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nret <= occ);

  assert_flow_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !openc);

  assert_trap_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !irq_take);
endmodule

bind commit_retire_unit commit_retire_chk #(.CW(CW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tail_ptr(tail_ptr), .head_ptr(head_ptr),
  .ent_done(ent_done[CW-1:0]), .ent_eof(ent_eof[CW-1:0]),
  .ent_branch(ent_branch), .ret_mask(ret_mask), .trap(trap),
  .irq_take(irq_take), .flush(flush)
);

// File: tb/commit_retire_unit_tb_top.sv
module commit_retire_unit_tb_top;
  localparam int CW = 4, SCAN = 8, FW = 4, TW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n, irq_req;
  logic [4:0]      tail_ptr, head_ptr;
  logic [SCAN-1:0] ent_done, ent_eof;
  logic [SCAN*FW-1:0] ent_fault;
  logic [CW-1:0]   ent_branch, ret_mask;
  logic [CW*TW-1:0] ent_tag, ret_tag;
  logic            trap, irq_take, flush;
  logic [FW-1:0]   trap_cause;

  commit_retire_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tail_ptr(tail_ptr), .ent_done(ent_done),
    .ent_fault(ent_fault), .ent_branch(ent_branch), .ent_eof(ent_eof),
    .ent_tag(ent_tag), .irq_req(irq_req), .head_ptr(head_ptr),
    .ret_mask(ret_mask), .ret_tag(ret_tag), .trap(trap),
    .trap_cause(trap_cause), .irq_take(irq_take), .flush(flush)
  );

  logic       r_done[16], r_br[16], r_eof[16];
  logic [3:0] r_flt[16];
  logic [5:0] r_tag[16];
  logic [5:0] tag_seq = 6'd1;

  always_comb begin
    for (int k = 0; k < SCAN; k++) begin
      ent_done[k]        = r_done[head_ptr[3:0] + 4'(k)];
      ent_eof[k]         = r_eof[head_ptr[3:0] + 4'(k)];
      ent_fault[k*FW +: FW] = r_flt[head_ptr[3:0] + 4'(k)];
    end
    for (int k = 0; k < CW; k++) begin
      ent_branch[k]         = r_br[head_ptr[3:0] + 4'(k)];
      ent_tag[k*TW +: TW]   = r_tag[head_ptr[3:0] + 4'(k)];
    end
  end

  typedef struct {
    logic [3:0]  mask;
    logic        trap;
    logic [3:0]  cause;
    logic        irq;
    logic [4:0]  head;
    logic [23:0] tags;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0;

  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (ret_mask !== it.mask || trap !== it.trap || trap_cause !== it.cause ||
          irq_take !== it.irq || head_ptr !== it.head || ret_tag !== it.tags ||
          flush !== (it.trap | it.irq)) begin
        failures++;
        $display("FAIL %s: mask=%b/%b trap=%b/%b cause=%h/%h irq=%b/%b flush=%b/%b head=%0d/%0d tags=%h/%h (actual/expected)",
                 it.req, ret_mask, it.mask, trap, it.trap, trap_cause, it.cause,
                 irq_take, it.irq, flush, it.trap | it.irq, head_ptr, it.head, ret_tag, it.tags);
      end
    end
  end

  task automatic put(input int idx, input logic d, input logic [3:0] f,
                     input logic b, input logic e);
    r_done[idx] = d; r_flt[idx] = f; r_br[idx] = b; r_eof[idx] = e;
    r_tag[idx] = tag_seq;
    tag_seq = tag_seq + 6'd1;
  endtask

  task automatic expect_cyc(input logic [3:0] m, input logic t, input logic [3:0] c,
                            input logic i, input logic [4:0] h, input string rq);
    item_t it;
    it.mask = m; it.trap = t; it.cause = c; it.irq = i; it.head = h; it.req = rq;
    it.tags = '0;
    for (int k = 0; k < 4; k++)
      if (m[k]) it.tags[k*6 +: 6] = r_tag[h[3:0] + 4'(k)];
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic ret(input logic [3:0] m, input logic [4:0] h, input string rq);
    expect_cyc(m, 1'b0, 4'h0, 1'b0, h, rq);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog: run did not complete (actual hung / expected done)");
    report();
  end

  initial begin
    rst_n = 1'b0; irq_req = 1'b0; tail_ptr = 5'd0;
    for (int i = 0; i < 16; i++) put(i, 1'b0, 4'h0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (head_ptr !== 5'd0 || ret_mask !== 4'b0 || trap !== 1'b0 || irq_take !== 1'b0 || flush !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: head=%0d/0 mask=%b/0000 trap=%b/0 irq=%b/0 flush=%b/0",
               head_ptr, ret_mask, trap, irq_take, flush);
    end
    rst_n = 1'b1;

    // R1/R2: width limit then stop at unfinished entry
    for (int i = 0; i < 5; i++) put(i, 1'b1, 4'h0, 1'b0, 1'b1);
    put(5, 1'b0, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd6;
    ret(4'b1111, 5'd0, "R1 full group");
    ret(4'b0001, 5'd4, "R2 stop at not-done");
    ret(4'b0000, 5'd5, "R2 head not done");
    r_done[5] = 1'b1;
    ret(4'b0001, 5'd5, "R1 late finish");
    ret(4'b0000, 5'd6, "R8 empty buffer");

    // R3: one branch per cycle
    put(6, 1'b1, 4'h0, 1'b1, 1'b1); put(7, 1'b1, 4'h0, 1'b0, 1'b1);
    put(8, 1'b1, 4'h0, 1'b1, 1'b1); put(9, 1'b1, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd10;
    ret(4'b0011, 5'd6, "R3 second branch waits");
    ret(4'b0011, 5'd8, "R3 branch next cycle");

    // R4: flow held until complete
    put(10, 1'b1, 4'h0, 1'b0, 1'b0); put(11, 1'b1, 4'h0, 1'b0, 1'b0);
    put(12, 1'b0, 4'h0, 1'b0, 1'b1); put(13, 1'b1, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd14;
    ret(4'b0000, 5'd10, "R4 flow incomplete");
    r_done[12] = 1'b1;
    ret(4'b1111, 5'd10, "R4 flow complete");

    // R5: long flow across wrap
    put(14, 1'b1, 4'h0, 1'b0, 1'b0); put(15, 1'b1, 4'h0, 1'b0, 1'b0);
    put(0, 1'b1, 4'h0, 1'b0, 1'b0);  put(1, 1'b1, 4'h0, 1'b0, 1'b0);
    put(2, 1'b1, 4'h0, 1'b0, 1'b0);  put(3, 1'b1, 4'h0, 1'b0, 1'b1);
    put(4, 1'b1, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd21;
    ret(4'b1111, 5'd14, "R5 long flow part 1");
    ret(4'b0111, 5'd18, "R5 long flow part 2");

    // R6/R7/R8: fault held, raised at head, stale after flush
    put(5, 1'b1, 4'h0, 1'b0, 1'b1); put(6, 1'b1, 4'h0, 1'b0, 1'b1);
    put(7, 1'b1, 4'h9, 1'b0, 1'b1); put(8, 1'b1, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd25;
    ret(4'b0011, 5'd21, "R6 fault not at head");
    expect_cyc(4'b0000, 1'b1, 4'h9, 1'b0, 5'd23, "R7 trap at head");
    tail_ptr = 5'd23;
    ret(4'b0000, 5'd23, "R8 flushed fault ignored");

    // R8: mispredict pulls tail back over a faulting entry
    put(7, 1'b1, 4'h0, 1'b1, 1'b1); put(8, 1'b1, 4'h3, 1'b0, 1'b1);
    put(9, 1'b1, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd26;
    tail_ptr = 5'd24;
    ret(4'b0001, 5'd23, "R8 retire before mispredict cut");
    ret(4'b0000, 5'd24, "R8 wrong-path fault silent");

    // R9: full buffer
    for (int i = 0; i < 16; i++) put(i, 1'b1, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd8;
    ret(4'b1111, 5'd24, "R9 full buffer");
    ret(4'b1111, 5'd28, "R9 drain");
    ret(4'b1111, 5'd0,  "R9 drain wrap");
    ret(4'b1111, 5'd4,  "R9 drain");
    ret(4'b0000, 5'd8,  "R9 drained empty");

    // R10/R11: interrupt deferred to flow boundary
    for (int i = 8; i < 13; i++) put(i, 1'b1, 4'h0, 1'b0, 1'b0);
    put(13, 1'b1, 4'h0, 1'b0, 1'b1); put(14, 1'b1, 4'h0, 1'b0, 1'b1);
    put(15, 1'b1, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd16;
    ret(4'b1111, 5'd8, "R10 flow opens");
    irq_req = 1'b1;
    ret(4'b0011, 5'd12, "R11 group ends at flow end");
    expect_cyc(4'b0000, 1'b0, 4'h0, 1'b1, 5'd14, "R10 interrupt at boundary");
    irq_req = 1'b0;
    ret(4'b0011, 5'd14, "R10 resume after interrupt");

    // R12: trap beats interrupt
    put(0, 1'b1, 4'h5, 1'b0, 1'b1);
    tail_ptr = 5'd17;
    irq_req = 1'b1;
    expect_cyc(4'b0000, 1'b1, 4'h5, 1'b0, 5'd16, "R12 trap wins");
    tail_ptr = 5'd16;
    expect_cyc(4'b0000, 1'b0, 4'h0, 1'b1, 5'd16, "R12 interrupt after trap");
    irq_req = 1'b0;

    // R7: fault inside a flow traps at flow start
    put(0, 1'b1, 4'h0, 1'b0, 1'b0); put(1, 1'b1, 4'h7, 1'b0, 1'b0);
    put(2, 1'b1, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd19;
    expect_cyc(4'b0000, 1'b1, 4'h7, 1'b0, 5'd16, "R7 fault inside flow");
    tail_ptr = 5'd16;
    ret(4'b0000, 5'd16, "R8 flushed flow silent");

    // R2: hole in done bits
    put(0, 1'b1, 4'h0, 1'b0, 1'b1); put(1, 1'b0, 4'h0, 1'b0, 1'b1);
    put(2, 1'b1, 4'h0, 1'b0, 1'b1); put(3, 1'b1, 4'h0, 1'b0, 1'b1);
    tail_ptr = 5'd20;
    ret(4'b0001, 5'd16, "R2 hole stops group");
    r_done[1] = 1'b1;
    ret(4'b0111, 5'd17, "R2 hole filled");
    ret(4'b0000, 5'd20, "R1 head at tail");

    report();
  end
endmodule